// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes fixed 32-byte interrupt vectors from an upstream source and stores each one in a circular buffer in system memory. The buffer is reached through a plain memory write port: one beat carries one whole vector. The block owns the write pointer. The consumer moves the read pointer, either by a direct register write or by a doorbell write whose index matches a configured offset.

When the ring fills up, one of two policies applies. In the first, the block keeps writing over unread entries and may raise a sticky overflow flag, which software clears with a pulse. In the second, it holds off the source until the consumer frees an entry. The current write pointer is always visible on a status output, with the overflow flag in its lowest bit. The same value can also be copied to a memory location each time it changes. An interrupt line stays high while unread entries exist.

Top module: `ivring_writer`

## Requirements
- R1: After reset the write pointer, read pointer and overflow flag are zero, `wptr_status` reads 0, `irq` is low and no memory write is issued.
- R2: Each accepted vector produces, on the following cycle, one memory write of the 256-bit vector at byte address {`base_hi`, `base_lo`, 8'h00} plus the write pointer. The write pointer then advances by 32 bytes and wraps at 2^(`size_log2`+2) bytes (`size_log2` is the base-2 log of the ring size in 32-bit words, clamped to 3..MAX_LOG2).
- R3: The ring is full when the advanced write pointer would equal the read pointer. A vector written into a full ring while `ovf_det_en` is 1 sets a sticky overflow flag, reported in bit 0 of `wptr_status`. Bits above bit 0 hold the byte write pointer, whose low five bits are always zero.
- R4: While `ovf_clr` is 1 the overflow flag is held at 0. The first full-ring write after `ovf_clr` returns to 0 sets the flag again.
- R5: With `ovf_det_en` 0 and `drain_en` 1, `vec_ready` is low while the ring is full, so no vector is written. Writing resumes once the read pointer moves.
- R6: With `wb_en` 1, every accepted write also issues, in the same cycle as the memory write, a writeback of the new `wptr_status` value to `wb_addr`.
- R7: While `ring_en` is 0, both pointers and the overflow flag are forced to zero, vectors are accepted and dropped with no memory write, and read-pointer updates are ignored.
- R8: A read-pointer update comes from `rptr_wr`, or from `db_wr` when `db_en` is 1 and `db_idx` equals `db_offset`. Doorbells with a different index, or with `db_en` 0, are ignored. The register write wins when both arrive in the same cycle. The written value is masked to the ring size and aligned to 32 bytes.
- R9: `irq` is high exactly when `ring_en` and `intr_en` are both 1 and the write pointer differs from the read pointer.
- R10: With both `ovf_det_en` and `drain_en` at 0, a full ring is overwritten and the overflow flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_en | input | 1 | Ring enable; 0 zeroes the pointers |
| intr_en | input | 1 | Interrupt enable |
| ovf_det_en | input | 1 | Overflow detection enable |
| drain_en | input | 1 | Stall-on-full enable (used when detection is off) |
| ovf_clr | input | 1 | Overflow flag clear, level sensitive |
| wb_en | input | 1 | Write-pointer writeback enable |
| db_en | input | 1 | Doorbell read-pointer update enable |
| size_log2 | input | 5 | Log2 of ring size in 32-bit words |
| base_lo | input | 32 | Ring base address bits [39:8] |
| base_hi | input | 8 | Ring base address bits [47:40] |
| wb_addr | input | 48 | Writeback target byte address |
| db_offset | input | DB_W | Doorbell index that updates the read pointer |
| rptr_wr | input | 1 | Read-pointer register write strobe |
| rptr_wdata | input | 32 | Read-pointer register write value (bytes) |
| db_wr | input | 1 | Doorbell write strobe |
| db_idx | input | DB_W | Doorbell write index |
| db_data | input | 32 | Doorbell write value (bytes) |
| vec_valid | input | 1 | Vector valid |
| vec_data | input | 256 | Vector payload |
| vec_ready | output | 1 | Vector accepted when high with valid |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | 48 | Ring memory byte address |
| mem_wdata | output | 256 | Ring memory write data |
| wb_we | output | 1 | Writeback write strobe |
| wb_waddr | output | 48 | Writeback byte address |
| wb_wdata | output | 32 | Writeback value (pointer and overflow flag) |
| wptr_status | output | 32 | Write pointer with overflow flag in bit 0 |
| irq | output | 1 | Unread-entries interrupt |

## Verification
The bench aims at the full-ring boundary under each policy. A one-entry ring is always full, which makes it the sharpest case: a design that tests fullness one entry late would overwrite in stall mode or miss the overflow flag. It times the overflow clear so that a vector arrives both while the clear is held and on the very next cycle; a design that only rearms on a later edge would lose that overflow. It also sends doorbells with a mismatched index, with doorbells disabled, and in the same cycle as a register write, all observed through `irq`; a wrong priority or decode would move the read pointer and flip the line. Disable and re-enable in the middle of traffic must leave both pointers at zero and drop vectors without a memory write.

// File: rtl/ivring_writer.sv
module ivring_writer #(
  parameter int MAX_LOG2 = 16,
  parameter int DB_W     = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ring_en,
  input  logic            intr_en,
  input  logic            ovf_det_en,
  input  logic            drain_en,
  input  logic            ovf_clr,
  input  logic            wb_en,
  input  logic            db_en,
  input  logic [4:0]      size_log2,
  input  logic [31:0]     base_lo,
  input  logic [7:0]      base_hi,
  input  logic [47:0]     wb_addr,
  input  logic [DB_W-1:0] db_offset,
  input  logic            rptr_wr,
  input  logic [31:0]     rptr_wdata,
  input  logic            db_wr,
  input  logic [DB_W-1:0] db_idx,
  input  logic [31:0]     db_data,
  input  logic            vec_valid,
  input  logic [255:0]    vec_data,
  output logic            vec_ready,
  output logic            mem_we,
  output logic [47:0]     mem_addr,
  output logic [255:0]    mem_wdata,
  output logic            wb_we,
  output logic [47:0]     wb_waddr,
  output logic [31:0]     wb_wdata,
  output logic [31:0]     wptr_status,
  output logic            irq
);
  localparam int PTR_W = MAX_LOG2 + 2;
  localparam logic [4:0] MIN_SZ = 5'd3;
  localparam logic [4:0] MAX_SZ = 5'(MAX_LOG2);

  logic [PTR_W-1:0] wptr_q, rptr_q, wnext, ptr_mask, wptr_d, rptr_d;
  logic [4:0]       sz_c;
  logic             ovf_q, ovf_d, full, stall_mode, do_wr, db_hit;
  logic [31:0]      status_d;

  assign sz_c = (size_log2 < MIN_SZ) ? MIN_SZ : ((size_log2 > MAX_SZ) ? MAX_SZ : size_log2);
  assign ptr_mask = ((PTR_W'(1) << (sz_c + 5'd2)) - PTR_W'(1)) & ~PTR_W'(31);

  assign wnext      = (wptr_q + PTR_W'(32)) & ptr_mask;
  assign full       = (wnext == rptr_q);
  assign stall_mode = !ovf_det_en && drain_en;
  assign vec_ready  = !ring_en || !full || !stall_mode;
  assign do_wr      = ring_en && vec_valid && vec_ready;
  assign db_hit     = db_wr && db_en && (db_idx == db_offset);

  assign wptr_d = do_wr ? wnext : wptr_q;
  assign rptr_d = rptr_wr ? (rptr_wdata[PTR_W-1:0] & ptr_mask)
                : db_hit  ? (db_data[PTR_W-1:0] & ptr_mask)
                :           rptr_q;
  assign ovf_d  = ovf_clr ? 1'b0 : (ovf_q || (do_wr && full && ovf_det_en));
  assign status_d = {{(32-PTR_W){1'b0}}, wptr_d[PTR_W-1:1], ovf_d};

  assign irq = ring_en && intr_en && (wptr_q != rptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !ring_en) begin
      wptr_q      <= '0;
      rptr_q      <= '0;
      ovf_q       <= 1'b0;
      mem_we      <= 1'b0;
      wb_we       <= 1'b0;
      wptr_status <= '0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      wb_waddr    <= '0;
      wb_wdata    <= '0;
    end else begin
      wptr_q      <= wptr_d;
      rptr_q      <= rptr_d;
      ovf_q       <= ovf_d;
      wptr_status <= status_d;
      mem_we      <= do_wr;
      wb_we       <= do_wr && wb_en;
      if (do_wr) begin
        mem_addr  <= {base_hi, base_lo, 8'h00} + 48'(wptr_q);
        mem_wdata <= vec_data;
        wb_waddr  <= wb_addr;
        wb_wdata  <= status_d;
      end
    end
  end

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[4:0] == 5'd0));

  // R4
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !wptr_status[0]);

  // R5
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_en && stall_mode && full && !rptr_wr && !db_hit) |=> !mem_we);

  // R6
  wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (mem_we && wb_wdata == wptr_status));

  // R7
  ring_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en |=> (wptr_status == 32'd0 && !mem_we && !wb_we));
endmodule

// File: tb/ivring_writer_tb.sv
module ivring_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] DB_OFF = 12'h05A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_en = 1'b1, intr_en = 1'b1, ovf_det_en = 1'b0, drain_en = 1'b0;
  logic ovf_clr = 1'b0, wb_en = 1'b0, db_en = 1'b0;
  logic [4:0] size_log2 = 5'd5;
  logic [31:0] base_lo = 32'h1234_5600;
  logic [7:0] base_hi = 8'hA5;
  logic [47:0] wb_addr = 48'h0000_BEEF_0040;
  logic [11:0] db_offset = DB_OFF;
  logic rptr_wr = 1'b0, db_wr = 1'b0, vec_valid = 1'b0;
  logic [31:0] rptr_wdata = '0, db_data = '0;
  logic [11:0] db_idx = '0;
  logic [255:0] vec_data = '0;
  logic vec_ready, mem_we, wb_we, irq;
  logic [47:0] mem_addr, wb_waddr;
  logic [255:0] mem_wdata;
  logic [31:0] wb_wdata, wptr_status;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [17:0] mw = '0, mr = '0;
  logic movf = 1'b0, ewe = 1'b0, ewb = 1'b0;
  logic [47:0] eaddr;
  logic [255:0] edata;
  logic [31:0] ewbd;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivring_writer u_dut (
    .clk, .rst_n, .ring_en, .intr_en, .ovf_det_en, .drain_en, .ovf_clr, .wb_en, .db_en,
    .size_log2, .base_lo, .base_hi, .wb_addr, .db_offset, .rptr_wr, .rptr_wdata,
    .db_wr, .db_idx, .db_data, .vec_valid, .vec_data, .vec_ready, .mem_we, .mem_addr,
    .mem_wdata, .wb_we, .wb_waddr, .wb_wdata, .wptr_status, .irq
  );

  function automatic logic [17:0] mask_of(input logic [4:0] s);
    return ((18'(1) << (s + 5'd2)) - 18'd1) & ~18'd31;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rptr_wr = 0; db_wr = 0; vec_valid = 0; ovf_clr = 0;
  endtask

  task automatic cycle();
    logic [17:0] m;
    logic full, exp_rdy, wr, novf;
    #1;
    m = mask_of(size_log2);
    full = ((mw + 18'd32) & m) == mr;
    exp_rdy = !ring_en || !full || !(!ovf_det_en && drain_en);
    chk(vec_ready === exp_rdy, "R5 vec_ready", 64'(vec_ready), 64'(exp_rdy));
    chk(irq === (ring_en && intr_en && mw != mr), "R9 irq", 64'(irq), 64'(ring_en && intr_en && mw != mr));
    wr = ring_en && vec_valid && exp_rdy;
    if (!ring_en) begin
      mw = '0; mr = '0; movf = 0; ewe = 0; ewb = 0;
    end else begin
      novf = ovf_clr ? 1'b0 : (movf || (wr && full && ovf_det_en));
      ewe = wr;
      eaddr = {base_hi, base_lo, 8'h00} + 48'(mw);
      edata = vec_data;
      if (wr) mw = (mw + 18'd32) & m;
      if (rptr_wr) mr = rptr_wdata[17:0] & m;
      else if (db_wr && db_en && db_idx == db_offset) mr = db_data[17:0] & m;
      movf = novf;
      ewb = wr && wb_en;
      ewbd = {14'd0, mw} | 32'(movf);
    end
    @(negedge clk);
    chk(mem_we === ewe, "R2 mem_we", 64'(mem_we), 64'(ewe));
    if (ewe) begin
      chk(mem_addr === eaddr, "R2 mem_addr", 64'(mem_addr), 64'(eaddr));
      chk(mem_wdata === edata, "R2 mem_wdata", mem_wdata[63:0], edata[63:0]);
    end
    chk(wptr_status === ({14'd0, mw} | 32'(movf)), "R3 wptr_status", 64'(wptr_status),
        64'({14'd0, mw} | 32'(movf)));
    chk(wb_we === ewb, "R6 wb_we", 64'(wb_we), 64'(ewb));
    if (ewb) begin
      chk(wb_wdata === ewbd, "R6 wb_wdata", 64'(wb_wdata), 64'(ewbd));
      chk(wb_waddr === wb_addr, "R6 wb_waddr", 64'(wb_waddr), 64'(wb_addr));
    end
  endtask

  task automatic push(input int n);
    for (int k = 0; k < n; k++) begin
      idle(); vec_valid = 1; vec_data = {8{$urandom}}; cycle();
    end
    idle();
  endtask

  task automatic ring_restart();
    idle(); ring_en = 0; cycle(); ring_en = 1; cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(wptr_status === 32'd0, "R1 status", 64'(wptr_status), 0);
    chk(irq === 1'b0, "R1 irq", 64'(irq), 0);
    chk(mem_we === 1'b0 && wb_we === 1'b0, "R1 no write", 64'(mem_we), 0);
    @(negedge clk);

    // R3 / R4: single-entry ring is always full
    size_log2 = 5'd3; ovf_det_en = 1; drain_en = 0; ring_restart();
    push(1);
    chk(wptr_status[0] === 1'b1, "R3 overflow set", 64'(wptr_status), 1);
    idle(); ovf_clr = 1; vec_valid = 1; vec_data = {8{$urandom}}; cycle();
    chk(wptr_status[0] === 1'b0, "R4 clear held", 64'(wptr_status), 0);
    push(1);
    chk(wptr_status[0] === 1'b1, "R4 rearm at once", 64'(wptr_status), 1);

    // R10: overwrite without flag
    ovf_det_en = 0; drain_en = 0; ring_restart();
    push(2);
    chk(mem_we === 1'b1 && wptr_status[0] === 1'b0, "R10 overwrite no flag", 64'(wptr_status), 0);

    // R5: stall with one-entry ring
    drain_en = 1; ring_restart();
    idle(); vec_valid = 1; cycle();
    chk(mem_we === 1'b0, "R5 stalled", 64'(mem_we), 0);

    // R7: disabled ring drops vectors
    idle(); ring_en = 0; vec_valid = 1; rptr_wr = 1; rptr_wdata = 32'h40; cycle();
    chk(mem_we === 1'b0 && wptr_status === 32'd0, "R7 dropped", 64'(wptr_status), 0);
    ring_en = 1; idle(); cycle();

    // R8: doorbell decode and priority
    size_log2 = 5'd5; drain_en = 0; wb_en = 1; ring_restart();
    push(2);
    chk(irq === 1'b1, "R8 pending", 64'(irq), 1);
    idle(); db_en = 1; db_wr = 1; db_idx = DB_OFF + 12'd1; db_data = 32'd64; cycle();
    chk(irq === 1'b1, "R8 mismatched doorbell ignored", 64'(irq), 1);
    idle(); db_wr = 1; db_idx = DB_OFF; db_data = 32'd64; cycle();
    chk(irq === 1'b0, "R8 doorbell hit", 64'(irq), 0);
    idle(); db_en = 0; db_wr = 1; db_idx = DB_OFF; db_data = 32'd0; cycle();
    chk(irq === 1'b0, "R8 doorbell disabled", 64'(irq), 0);
    idle(); rptr_wr = 1; rptr_wdata = 32'd0; cycle();
    chk(irq === 1'b1, "R8 register write", 64'(irq), 1);
    idle(); db_en = 1; rptr_wr = 1; rptr_wdata = 32'd64; db_wr = 1; db_idx = DB_OFF; db_data = 32'd0; cycle();
    chk(irq === 1'b0, "R8 register wins", 64'(irq), 0);
    idle();

    // random traffic under all policies
    for (int c = 0; c < 16; c++) begin
      size_log2 = 5'(3 + ($urandom % 4));
      ovf_det_en = $urandom % 2; drain_en = $urandom % 2;
      wb_en = $urandom % 2; db_en = $urandom % 2; intr_en = ($urandom % 4) != 0;
      for (int i = 0; i < 400; i++) begin
        ring_en = ($urandom % 100) != 0;
        vec_valid = ($urandom % 10) < 6;
        vec_data = {8{$urandom}};
        rptr_wr = ($urandom % 6) == 0;
        rptr_wdata = $urandom & 32'h0003_FFE0;
        db_wr = ($urandom % 8) == 0;
        db_idx = (($urandom % 4) == 0) ? 12'($urandom) : DB_OFF;
        db_data = $urandom & 32'h0003_FFE0;
        ovf_clr = ($urandom % 20) == 0;
        cycle();
      end
      idle(); ring_en = 1;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule